// File: doc/BRIEF.md
# Virtualized Interrupt-Pending CSR Unit

This block holds the interrupt-pending state of a hart that supports hypervisor virtualization and serves CSR read, write, set and clear requests against it. One physical set of pending bits is shown through four CSR addresses: a machine view, a hypervisor view, a supervisor view and a virtual-supervisor view. Each view shows its own subset of the bits, and each has its own set of writable bits. External-interrupt and timer inputs are merged into the bits that hardware drives.

A request carries the CSR address, the current privilege level, the virtualization flag and, for modifying operations, an operand. In the same cycle the unit returns the read data and an exception code (none, illegal instruction, virtual instruction). A legal modifying request updates the stored bits at the next rising clock edge. While virtualization is active, the supervisor address is silently steered to the virtual-supervisor view. A direct access to the virtual-supervisor or hypervisor address from a virtualized mode traps instead.

Top module: `ipend_csr`

## Requirements
- R1: After reset every stored pending bit is 0, so with all interrupt inputs low a machine-view read (address 0x344) returns 0. While req_i is low, rdata_o and exc_o are 0.
- R2: The machine view (0x344, needs privilege 3) shows bit 1 = SSIP, bit 2 = VSSIP, bit 5 = STIP (stored bit OR supervisor timer input), bit 6 = VSTIP (the VS timer input alone), bit 9 = SEIP (stored bit OR supervisor external input) and bit 10 = VSEIP (stored bit OR VS external input). Every other bit reads 0.
- R3: A machine-view write changes the stored bits 1, 2, 5, 9 and 10. Bit 6 and all other bits ignore the write. VSSIP and VSEIP are the same storage as in the hypervisor view.
- R4: The hypervisor view (0x644, needs privilege 1 or higher with V=0) shows only bits 2, 6 and 10 of the machine view. Only bits 2 and 10 are writable through it.
- R5: The supervisor view (0x144 with V=0, needs privilege 1) shows only bits 1, 5 and 9. Only bit 1 (SSIP) is writable; STIP and SEIP are read-only there.
- R6: The virtual-supervisor view (0x244) shows VSSIP, VSTIP and VSEIP moved down one position to bits 1, 5 and 9. Only bit 1 is writable, and a write to it lands in VSSIP.
- R7: With V=1 and privilege below 3, an access to 0x144 uses the virtual-supervisor view of R6 and never touches SSIP. V is ignored at privilege 3.
- R8: With V=1 and privilege below 3, any access to 0x244 or 0x644 gives exc_o = 2 (virtual instruction), returns rdata_o = 0 and changes no stored bit.
- R9: exc_o = 1 (illegal instruction) for an address outside the four views, or for a privilege level below the view's minimum. The exception is the case of V=1 at privilege 0 on 0x144, which gives exc_o = 2. Such a request returns 0 and changes nothing.
- R10: Operation codes are 0 = read only, 1 = write, 2 = set bits, 3 = clear bits. Set and clear act on the stored bits, not on the input-merged values. With an all-zero operand, set and clear perform no write, and code 0 never writes.
- R11: Read data and exception code are valid in the cycle of the request. A write is visible to a request in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Request valid |
| op_i | input | 2 | Operation: 0 read, 1 write, 2 set, 3 clear |
| addr_i | input | 12 | CSR address |
| priv_i | input | 2 | Current privilege: 0 user, 1 supervisor, 3 machine |
| virt_i | input | 1 | Virtualization flag V |
| wdata_i | input | XLEN | Write value or set/clear operand |
| ext_s_i | input | 1 | Supervisor external interrupt level |
| tmr_s_i | input | 1 | Supervisor timer interrupt level |
| ext_vs_i | input | 1 | VS external interrupt level |
| tmr_vs_i | input | 1 | VS timer interrupt level |
| rdata_o | output | XLEN | Read value of the selected view |
| exc_o | output | 2 | 0 none, 1 illegal instruction, 2 virtual instruction |

## Verification
A wrong stored bit stays hidden until some view reads it. For that reason every request in the sweep is followed by a machine-view read in the next cycle, so a corrupted or missed update shows within one cycle. A wrong view selection or permission decision is combinational and shows at rdata_o or exc_o in the cycle of the request itself. The case of a trapped request that still writes is caught by the following readback.

// File: rtl/ipend_pkg.sv
package ipend_pkg;

   localparam int unsigned PW = 11;
   typedef logic [PW-1:0] pvec_t;

   localparam int unsigned B_SSIP  = 1;
   localparam int unsigned B_VSSIP = 2;
   localparam int unsigned B_STIP  = 5;
   localparam int unsigned B_VSTIP = 6;
   localparam int unsigned B_SEIP  = 9;
   localparam int unsigned B_VSEIP = 10;

   localparam logic [1:0] PRV_U = 2'd0;
   localparam logic [1:0] PRV_S = 2'd1;
   localparam logic [1:0] PRV_M = 2'd3;

   typedef enum logic [1:0] {VW_M = 2'd0, VW_H = 2'd1, VW_S = 2'd2, VW_VS = 2'd3} view_e;
   typedef enum logic [1:0] {EXC_NONE = 2'd0, EXC_ILL = 2'd1, EXC_VIRT = 2'd2} exc_e;
   typedef enum logic [1:0] {OP_RD = 2'd0, OP_RW = 2'd1, OP_RS = 2'd2, OP_RC = 2'd3} op_e;

   function automatic pvec_t bitv(input int unsigned b);
      return pvec_t'(1) << b;
   endfunction

   localparam pvec_t S_LANE  = bitv(B_SSIP) | bitv(B_STIP) | bitv(B_SEIP);
   localparam pvec_t VS_LANE = bitv(B_VSSIP) | bitv(B_VSTIP) | bitv(B_VSEIP);
   localparam pvec_t STORE_MASK = bitv(B_SSIP) | bitv(B_VSSIP) | bitv(B_STIP)
                                | bitv(B_SEIP) | bitv(B_VSEIP);

   // Visible bits, in the coordinates of the view itself
   function automatic pvec_t view_vis(input view_e v);
      case (v)
         VW_M:    return S_LANE | VS_LANE;
         VW_H:    return VS_LANE;
         default: return S_LANE;
      endcase
   endfunction

   // Writable bits, in the coordinates of the view itself
   function automatic pvec_t view_wr(input view_e v);
      case (v)
         VW_M:    return STORE_MASK;
         VW_H:    return bitv(B_VSSIP) | bitv(B_VSEIP);
         default: return bitv(B_SSIP);
      endcase
   endfunction

   // Views that present the VS lane in supervisor positions
   function automatic logic view_shift(input view_e v);
      return (v == VW_VS);
   endfunction

endpackage

// File: rtl/ipend_decode.sv
module ipend_decode
   import ipend_pkg::*;
#(
   parameter logic [11:0] A_S  = 12'h144,
   parameter logic [11:0] A_VS = 12'h244,
   parameter logic [11:0] A_M  = 12'h344,
   parameter logic [11:0] A_H  = 12'h644
)(
   input  logic        req_i,
   input  logic [11:0] addr_i,
   input  logic [1:0]  priv_i,
   input  logic        virt_i,
   output view_e       view_o,
   output exc_e        exc_o
);

   if (A_S == A_VS || A_S == A_M || A_S == A_H ||
       A_VS == A_M || A_VS == A_H || A_M == A_H) begin : g_addr_clash
      $error("ipend_decode: view addresses must be distinct");
   end

   logic       eff_v;
   logic       hit;
   logic       hyp;
   logic [1:0] min_lvl;

   always_comb begin
      eff_v   = virt_i && (priv_i != PRV_M);
      view_o  = VW_M;
      hit     = 1'b1;
      hyp     = 1'b0;
      min_lvl = PRV_S;
      case (addr_i)
         A_M: begin
            view_o  = VW_M;
            min_lvl = PRV_M;
         end
         A_H: begin
            view_o = VW_H;
            hyp    = 1'b1;
         end
         A_VS: begin
            view_o = VW_VS;
            hyp    = 1'b1;
         end
         A_S: view_o = eff_v ? VW_VS : VW_S;
         default: hit = 1'b0;
      endcase

      if (!req_i)
         exc_o = EXC_NONE;
      else if (!hit)
         exc_o = EXC_ILL;
      else if (eff_v && hyp)
         exc_o = EXC_VIRT;
      else if (priv_i < min_lvl)
         exc_o = (eff_v && addr_i == A_S) ? EXC_VIRT : EXC_ILL;
      else
         exc_o = EXC_NONE;
   end

endmodule

// File: rtl/ipend_view.sv
module ipend_view
   import ipend_pkg::*;
(
   input  view_e view_i,
   input  pvec_t live_i,
   input  pvec_t sw_i,
   output pvec_t rd_o,
   output pvec_t old_o,
   output pvec_t wmask_o,
   output logic  shift_o
);

   pvec_t vis;
   pvec_t wr;

   always_comb begin
      vis     = view_vis(view_i);
      wr      = view_wr(view_i);
      shift_o = view_shift(view_i);
      if (shift_o) begin
         rd_o    = (live_i >> 1) & vis;
         old_o   = (sw_i >> 1) & vis;
         wmask_o = wr << 1;
      end else begin
         rd_o    = live_i & vis;
         old_o   = sw_i & vis;
         wmask_o = wr;
      end
   end

endmodule

// File: rtl/ipend_store.sv
module ipend_store
   import ipend_pkg::*;
#(
   parameter pvec_t MASK = STORE_MASK
)(
   input  logic  clk_i,
   input  logic  rst_ni,
   input  pvec_t we_i,
   input  pvec_t d_i,
   output pvec_t q_o
);

   for (genvar i = 0; i < PW; i++) begin : g_bit
      if (MASK[i]) begin : g_flop
         logic bit_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)
               bit_q <= 1'b0;
            else if (we_i[i])
               bit_q <= d_i[i];
         end
         assign q_o[i] = bit_q;
      end else begin : g_tie
         assign q_o[i] = 1'b0;
      end
   end

endmodule

// File: rtl/ipend_csr.sv
module ipend_csr
   import ipend_pkg::*;
#(
   parameter int unsigned XLEN = 32,
   parameter logic [11:0] A_S  = 12'h144,
   parameter logic [11:0] A_VS = 12'h244,
   parameter logic [11:0] A_M  = 12'h344,
   parameter logic [11:0] A_H  = 12'h644
)(
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            req_i,
   input  logic [1:0]      op_i,
   input  logic [11:0]     addr_i,
   input  logic [1:0]      priv_i,
   input  logic            virt_i,
   input  logic [XLEN-1:0] wdata_i,
   input  logic            ext_s_i,
   input  logic            tmr_s_i,
   input  logic            ext_vs_i,
   input  logic            tmr_vs_i,
   output logic [XLEN-1:0] rdata_o,
   output logic [1:0]      exc_o
);

   if (XLEN < PW) begin : g_xlen_small
      $error("ipend_csr: XLEN must hold all pending bits");
   end

   view_e view;
   exc_e  exc;
   pvec_t sw_q;
   pvec_t live;
   pvec_t rd_view;
   pvec_t old_view;
   pvec_t wmask;
   pvec_t new_view;
   pvec_t new_full;
   pvec_t we;
   logic  shift;
   logic  wr_en;
   op_e   op;

   assign op = op_e'(op_i);

   ipend_decode #(
      .A_S (A_S),
      .A_VS(A_VS),
      .A_M (A_M),
      .A_H (A_H)
   ) u_decode (
      .req_i (req_i),
      .addr_i(addr_i),
      .priv_i(priv_i),
      .virt_i(virt_i),
      .view_o(view),
      .exc_o (exc)
   );

   always_comb begin
      live          = sw_q;
      live[B_STIP]  = sw_q[B_STIP] | tmr_s_i;
      live[B_SEIP]  = sw_q[B_SEIP] | ext_s_i;
      live[B_VSEIP] = sw_q[B_VSEIP] | ext_vs_i;
      live[B_VSTIP] = tmr_vs_i;
   end

   ipend_view u_view (
      .view_i (view),
      .live_i (live),
      .sw_i   (sw_q),
      .rd_o   (rd_view),
      .old_o  (old_view),
      .wmask_o(wmask),
      .shift_o(shift)
   );

   always_comb begin
      case (op)
         OP_RW:   new_view = wdata_i[PW-1:0];
         OP_RS:   new_view = old_view | wdata_i[PW-1:0];
         OP_RC:   new_view = old_view & ~wdata_i[PW-1:0];
         default: new_view = old_view;
      endcase
      new_full = shift ? (new_view << 1) : new_view;
   end

   assign wr_en = req_i && (exc == EXC_NONE) && (op != OP_RD) &&
                  ((op == OP_RW) || (wdata_i != '0));
   assign we    = wmask & {PW{wr_en}};

   ipend_store #(
      .MASK(STORE_MASK)
   ) u_store (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .we_i  (we),
      .d_i   (new_full),
      .q_o   (sw_q)
   );

   assign rdata_o = (req_i && exc == EXC_NONE) ? XLEN'(rd_view) : '0;
   assign exc_o   = exc;

endmodule

// File: rtl/ipend_csr_chk.sv
module ipend_csr_chk #(
   parameter int unsigned XLEN = 32,
   parameter logic [11:0] A_S  = 12'h144,
   parameter logic [11:0] A_VS = 12'h244,
   parameter logic [11:0] A_M  = 12'h344,
   parameter logic [11:0] A_H  = 12'h644
)(
   input logic            clk_i,
   input logic            rst_ni,
   input logic            req_i,
   input logic [1:0]      op_i,
   input logic [11:0]     addr_i,
   input logic [1:0]      priv_i,
   input logic            virt_i,
   input logic [XLEN-1:0] wdata_i,
   input logic            tmr_vs_i,
   input logic [XLEN-1:0] rdata_o,
   input logic [1:0]      exc_o,
   input logic [10:0]     sw_q
);

   // R8
   virt_direct_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_i && virt_i && priv_i != 2'd3 && (addr_i == A_VS || addr_i == A_H))
      |-> (exc_o == 2'd2));

   // R8
   trap_nowrite_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_i && exc_o != 2'd0) |=> $stable(sw_q));

   // R9
   low_priv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_i && !virt_i && priv_i == 2'd0 && (addr_i == A_S || addr_i == A_M))
      |-> (exc_o == 2'd1));

   // R9
   trap_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (exc_o != 2'd0) |-> (rdata_o == '0));

   // R10
   zero_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_i && (op_i == 2'd2 || op_i == 2'd3 || op_i == 2'd0) && wdata_i == '0)
      |=> $stable(sw_q));

   // R2
   vstip_live_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_i && exc_o == 2'd0 && addr_i == A_M) |-> (rdata_o[6] == tmr_vs_i));

   // R1
   idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !req_i |-> (rdata_o == '0 && exc_o == 2'd0));

   // R6
   always_comb begin
      if (rst_ni) begin
         unused_bits_chk: assert (rdata_o[0] == 1'b0 && rdata_o[XLEN-1:11] == '0);
      end
   end

endmodule

bind ipend_csr ipend_csr_chk #(
   .XLEN(XLEN),
   .A_S (A_S),
   .A_VS(A_VS),
   .A_M (A_M),
   .A_H (A_H)
) u_ipend_csr_chk (
   .clk_i   (clk_i),
   .rst_ni  (rst_ni),
   .req_i   (req_i),
   .op_i    (op_i),
   .addr_i  (addr_i),
   .priv_i  (priv_i),
   .virt_i  (virt_i),
   .wdata_i (wdata_i),
   .tmr_vs_i(tmr_vs_i),
   .rdata_o (rdata_o),
   .exc_o   (exc_o),
   .sw_q    (sw_q)
);

// File: tb/test_ipend_csr.sv
module test_ipend_csr;

   logic        clk_i = 1'b0;
   logic        rst_ni = 1'b0;
   logic        req_i = 1'b0;
   logic [1:0]  op_i = 2'd0;
   logic [11:0] addr_i = 12'h0;
   logic [1:0]  priv_i = 2'd0;
   logic        virt_i = 1'b0;
   logic [31:0] wdata_i = 32'h0;
   logic        ext_s_i = 1'b0;
   logic        tmr_s_i = 1'b0;
   logic        ext_vs_i = 1'b0;
   logic        tmr_vs_i = 1'b0;
   logic [31:0] rdata_o;
   logic [1:0]  exc_o;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   // model state
   bit m_ssip, m_stip, m_seip, m_vssip, m_vseip;

   always #5 clk_i = ~clk_i;

   ipend_csr #(.XLEN(32)) i_ipend_csr (
      .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .op_i(op_i),
      .addr_i(addr_i), .priv_i(priv_i), .virt_i(virt_i), .wdata_i(wdata_i),
      .ext_s_i(ext_s_i), .tmr_s_i(tmr_s_i), .ext_vs_i(ext_vs_i), .tmr_vs_i(tmr_vs_i),
      .rdata_o(rdata_o), .exc_o(exc_o)
   );

   task automatic check(input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   function automatic logic [10:0] img(input bit s_ssip, s_stip, s_seip, s_vssip,
                                       s_vseip, s_vstip);
      logic [10:0] f = '0;
      f[1] = s_ssip; f[2] = s_vssip; f[5] = s_stip;
      f[6] = s_vstip; f[9] = s_seip; f[10] = s_vseip;
      return f;
   endfunction

   function automatic logic [1:0] exp_exc(input logic [11:0] a, input logic [1:0] p,
                                          input logic v);
      bit ev = v && (p != 2'd3);
      if (a != 12'h144 && a != 12'h244 && a != 12'h344 && a != 12'h644) return 2'd1;
      if (ev && (a == 12'h244 || a == 12'h644)) return 2'd2;
      if (a == 12'h344 && p != 2'd3) return 2'd1;
      if (p == 2'd0) return (ev && a == 12'h144) ? 2'd2 : 2'd1;
      return 2'd0;
   endfunction

   // kind: 0 machine, 1 hyp, 2 sup, 3 virtual-sup
   function automatic int kind_of(input logic [11:0] a, input logic [1:0] p,
                                  input logic v);
      bit ev = v && (p != 2'd3);
      if (a == 12'h344) return 0;
      if (a == 12'h644) return 1;
      if (a == 12'h144 && !ev) return 2;
      return 3;
   endfunction

   function automatic logic [10:0] view_of(input int k, input logic [10:0] f);
      case (k)
         0: return f & 11'h666;
         1: return f & 11'h444;
         2: return f & 11'h222;
         default: return (f >> 1) & 11'h222;
      endcase
   endfunction

   function automatic string tag_of(input logic [11:0] a, input logic [1:0] p,
                                    input logic v, input logic [1:0] op,
                                    input logic [31:0] w);
      logic [1:0] e = exp_exc(a, p, v);
      if (e == 2'd2) return "R8";
      if (e == 2'd1) return "R9";
      if (op >= 2'd2 && w == 32'h0) return "R10";
      if (a == 12'h144 && v && p != 2'd3) return "R7";
      case (a)
         12'h144: return "R5";
         12'h244: return "R6";
         12'h644: return "R4";
         default: return "R2";
      endcase
   endfunction

   task automatic apply(input logic [11:0] a, input logic [1:0] p, input logic v,
                        input logic [1:0] op, input logic [31:0] w,
                        input logic es, ts, evs, tvs, input string tag);
      logic [1:0]  ee;
      logic [10:0] live, sw, oldv, nv;
      int k;
      @(negedge clk_i);
      req_i = 1'b1; addr_i = a; priv_i = p; virt_i = v; op_i = op; wdata_i = w;
      ext_s_i = es; tmr_s_i = ts; ext_vs_i = evs; tmr_vs_i = tvs;
      #1;
      ee   = exp_exc(a, p, v);
      k    = kind_of(a, p, v);
      live = img(m_ssip, m_stip | ts, m_seip | es, m_vssip, m_vseip | evs, tvs);
      check(tag, "exc", {30'd0, exc_o}, {30'd0, ee});
      check(tag, "rdata", rdata_o, (ee == 2'd0) ? {21'd0, view_of(k, live)} : 32'd0);
      if (ee == 2'd0 && op != 2'd0 && (op == 2'd1 || w != 32'h0)) begin
         sw   = img(m_ssip, m_stip, m_seip, m_vssip, m_vseip, 1'b0);
         oldv = view_of(k, sw);
         case (op)
            2'd1: nv = w[10:0];
            2'd2: nv = oldv | w[10:0];
            default: nv = oldv & ~w[10:0];
         endcase
         case (k)
            0: begin
               m_ssip = nv[1]; m_vssip = nv[2]; m_stip = nv[5];
               m_seip = nv[9]; m_vseip = nv[10];
            end
            1: begin m_vssip = nv[2]; m_vseip = nv[10]; end
            2: m_ssip = nv[1];
            default: m_vssip = nv[1];
         endcase
      end
      @(posedge clk_i);
      #1;
      req_i = 1'b0;
   endtask

   // R3 R11: machine-view readback one cycle after any request
   task automatic readback(input logic es, ts, evs, tvs);
      apply(12'h344, 2'd3, 1'b0, 2'd0, 32'h0, es, ts, evs, tvs, "R3");
   endtask

   initial begin
      repeat (200000) @(posedge clk_i);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk_i);
      #1;
      // R1 idle outputs under reset release
      rst_ni = 1'b1;
      #1;
      check("R1", "idle rdata", rdata_o, 32'h0);
      check("R1", "idle exc", {30'd0, exc_o}, 32'h0);
      apply(12'h344, 2'd3, 1'b0, 2'd0, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, "R1");

      // R3: machine write of all ones keeps bit 6 and outer bits out
      apply(12'h344, 2'd3, 1'b0, 2'd1, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0, 1'b0, "R3");
      readback(1'b0, 1'b0, 1'b0, 1'b0);
      // R5: supervisor clear of everything only drops SSIP
      apply(12'h144, 2'd1, 1'b0, 2'd3, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0, 1'b0, "R5");
      readback(1'b0, 1'b0, 1'b0, 1'b0);
      // R7: redirected clear only drops VSSIP
      apply(12'h144, 2'd1, 1'b1, 2'd3, 32'h2, 1'b0, 1'b0, 1'b0, 1'b0, "R7");
      readback(1'b0, 1'b0, 1'b0, 1'b0);
      // R10: set with stored SEIP clear, input high, zero-ish operand elsewhere
      apply(12'h344, 2'd3, 1'b0, 2'd3, 32'h200, 1'b1, 1'b0, 1'b0, 1'b0, "R10");
      apply(12'h344, 2'd3, 1'b0, 2'd2, 32'h2, 1'b1, 1'b0, 1'b0, 1'b0, "R10");
      readback(1'b0, 1'b0, 1'b0, 1'b0);
      // R4: hypervisor write reaches the shared VS storage
      apply(12'h644, 2'd1, 1'b0, 2'd1, 32'h444, 1'b0, 1'b0, 1'b0, 1'b0, "R4");
      readback(1'b0, 1'b0, 1'b0, 1'b1);

      // near-exhaustive sweep
      for (int ai = 0; ai < 5; ai++) begin
         for (int pi = 0; pi < 3; pi++) begin
            for (int vi = 0; vi < 2; vi++) begin
               for (int oi = 0; oi < 4; oi++) begin
                  for (int ri = 0; ri < 4; ri++) begin
                     logic [11:0] a;
                     logic [1:0]  p;
                     logic [31:0] w;
                     logic [3:0]  inp;
                     case (ai)
                        0: a = 12'h144;
                        1: a = 12'h244;
                        2: a = 12'h344;
                        3: a = 12'h644;
                        default: a = 12'h145;
                     endcase
                     p   = (pi == 2) ? 2'd3 : 2'(pi);
                     w   = (ri == 0) ? 32'h0 : $urandom;
                     inp = 4'($urandom);
                     apply(a, p, vi[0], oi[1:0], w, inp[0], inp[1], inp[2], inp[3],
                           tag_of(a, p, vi[0], oi[1:0], w));
                     inp = 4'($urandom);
                     readback(inp[0], inp[1], inp[2], inp[3]);
                  end
               end
            end
         end
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

endmodule